// File: doc/BRIEF.md
# Deterministic Starfield Generator

This block marks sparse star pixels on a raster. The stars look scattered at random, but the same pattern appears on every frame. An 8-bit counter is built as two cascaded 4-bit stages. It advances once for each enabled pixel. When the counter reaches all ones, the current pixel is a star. On that same pixel the counter reloads a start value made of beam-position bits taken in a fixed, scrambled order. The gap to the next star therefore depends on where the beam was at the moment of each reload.

The raster timing supplies a pixel enable, the horizontal and vertical beam counters, and a frame-start pulse that comes with the first pixel of each frame. Frame start sets the counter to a fixed seed. Because the beam counters repeat exactly, the counter retraces the same sequence on every frame. The bit order used for the reload and the seed are compile-time parameters.

Top module: `starfield_gen`

## Requirements
- R1: The counter is CNT_W = STAGE_W*NUM_STAGES bits (default 8), built from NUM_STAGES cascaded STAGE_W-bit stages. On every enabled pixel that is neither a star nor a frame start, it increases by one, and the carry passes from the lower stage to the upper one.
- R2: `starPixel` is high exactly during an enabled pixel (`pixEn`=1, `frameStart`=0) for which the counter holds all ones. It is low otherwise.
- R3: On a star pixel, counter bit i loads bit RELOAD_MAP[8*i+7:8*i] of the source vector {vCount, hCount}. Source index 0 is hCount[0], and index HCNT_W is vCount[0].
- R4: A pixel with `pixEn`=1 and `frameStart`=1 loads FRAME_SEED into the counter and never produces a star, whatever the counter holds.
- R5: While `pixEn` is 0, the counter holds its value and `starPixel` is 0, whatever the other inputs do.
- R6: After reset the counter holds FRAME_SEED and `starPixel` is 0.
- R7: Two frames with identical beam sequences produce identical star positions, even when idle cycles with `pixEn`=0 are inserted differently.
- R8: The distance between consecutive stars is not constant. It changes with the beam position at each reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pixEn | input | 1 | Pixel clock enable; one enabled cycle per pixel |
| hCount | input | HCNT_W (9) | Horizontal beam counter |
| vCount | input | VCNT_W (8) | Vertical beam counter |
| frameStart | input | 1 | High with the first pixel of a frame |
| starPixel | output | 1 | Current pixel is a star |

## Verification
Assertions check on every cycle that:
- the control strobes are mutually exclusive;
- an enabled count step adds exactly one across the stage boundary, and each full stage wraps to zero;
- frame start lands on the seed;
- an idle cycle leaves the counter unchanged;
- a star is never raised on an idle or frame-start cycle.

The reload permutation, frame-to-frame repetition under differently placed stalls, and the variation of star gaps can only be shown by the bench. It runs whole frames of a reduced raster against an arithmetic model of the counter.

// File: rtl/starfield_pkg.sv
package starfield_pkg;

  // Strobes from control to datapath; at most one is active per cycle.
  typedef struct packed {
    logic seedLoad;  // frame start: load the seed
    logic mapLoad;   // star pixel: load the permuted beam bits
    logic count;     // ordinary enabled pixel: increment
  } ctrlStrobe_t;

endpackage

// File: rtl/starfield_stage.sv
module starfield_stage #(
  parameter int unsigned STAGE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               countEn,
  input  logic               loadEn,
  input  logic [STAGE_W-1:0] loadVal,
  input  logic [STAGE_W-1:0] resetVal,
  output logic [STAGE_W-1:0] q,
  output logic               full
);

  always_ff @(posedge clk) begin
    if (!rst_n)       q <= resetVal;
    else if (loadEn)  q <= loadVal;
    else if (countEn) q <= q + STAGE_W'(1);
  end

  assign full = &q;

  // R1: a full stage that is stepped wraps to zero (its carry goes upward)
  assert_stage_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (countEn && !loadEn && full) |=> (q == '0));

endmodule

// File: rtl/starfield_ctrl.sv
module starfield_ctrl
  import starfield_pkg::*;
(
  input  logic        pixEn,
  input  logic        frameStart,
  input  logic        termCount,
  output ctrlStrobe_t strobe,
  output logic        starPixel
);

  always_comb begin
    strobe          = '0;
    strobe.seedLoad = pixEn && frameStart;
    strobe.mapLoad  = pixEn && !frameStart && termCount;
    strobe.count    = pixEn && !frameStart && !termCount;
  end

  assign starPixel = strobe.mapLoad;

endmodule

// File: rtl/starfield_dp.sv
module starfield_dp
  import starfield_pkg::*;
#(
  parameter int unsigned STAGE_W    = 4,
  parameter int unsigned NUM_STAGES = 2,
  parameter int unsigned HCNT_W     = 9,
  parameter int unsigned VCNT_W     = 8,
  parameter logic [STAGE_W*NUM_STAGES*8-1:0] RELOAD_MAP = '0,
  parameter logic [STAGE_W*NUM_STAGES-1:0]   FRAME_SEED = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [HCNT_W-1:0] hCount,
  input  logic [VCNT_W-1:0] vCount,
  output logic              termCount
);

  localparam int unsigned CNT_W = STAGE_W * NUM_STAGES;
  localparam int unsigned SRC_W = HCNT_W + VCNT_W;

  logic [SRC_W-1:0]      srcVec;
  logic [CNT_W-1:0]      reloadVal;
  logic [CNT_W-1:0]      loadVal;
  logic [CNT_W-1:0]      cnt;
  logic [NUM_STAGES:0]   carry;
  logic [NUM_STAGES-1:0] stageFull;
  logic                  loadEn;

  assign srcVec = {vCount, hCount};

  // Fixed bit permutation of the beam position into the reload value.
  for (genvar i = 0; i < CNT_W; i++) begin : g_perm
    localparam int SRC_IDX = int'(RELOAD_MAP[i*8 +: 8]);
    if (SRC_IDX >= int'(SRC_W)) begin : g_bad
      $error("reload map index out of range");
    end
    assign reloadVal[i] = srcVec[SRC_IDX];
  end

  assign loadEn   = strobe.seedLoad || strobe.mapLoad;
  assign loadVal  = strobe.seedLoad ? FRAME_SEED : reloadVal;
  assign carry[0] = strobe.count;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    starfield_stage #(.STAGE_W(STAGE_W)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .countEn  (carry[s]),
      .loadEn   (loadEn),
      .loadVal  (loadVal[s*STAGE_W +: STAGE_W]),
      .resetVal (FRAME_SEED[s*STAGE_W +: STAGE_W]),
      .q        (cnt[s*STAGE_W +: STAGE_W]),
      .full     (stageFull[s])
    );
    assign carry[s+1] = carry[s] && stageFull[s];
  end

  assign termCount = &stageFull;

  // R1: strobes from control never overlap
  assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.seedLoad, strobe.mapLoad, strobe.count}));

  // R1: an enabled count step adds exactly one across all stages
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.count |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

  // R4: frame start lands on the seed
  assert_seed_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.seedLoad |=> (cnt == FRAME_SEED));

  // R5: no strobe means the counter holds
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe == '0) |=> $stable(cnt));

endmodule

// File: rtl/starfield_gen.sv
module starfield_gen
  import starfield_pkg::*;
#(
  parameter int unsigned STAGE_W    = 4,
  parameter int unsigned NUM_STAGES = 2,
  parameter int unsigned HCNT_W     = 9,
  parameter int unsigned VCNT_W     = 8,
  // 8-bit source index per counter bit, bit 0 in the lowest field.
  parameter logic [STAGE_W*NUM_STAGES*8-1:0] RELOAD_MAP =
    {8'd11, 8'd8, 8'd15, 8'd1, 8'd13, 8'd6, 8'd9, 8'd3},
  parameter logic [STAGE_W*NUM_STAGES-1:0] FRAME_SEED = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pixEn,
  input  logic [HCNT_W-1:0] hCount,
  input  logic [VCNT_W-1:0] vCount,
  input  logic              frameStart,
  output logic              starPixel
);

  ctrlStrobe_t strobe;
  logic        termCount;

  starfield_ctrl u_ctrl (
    .pixEn      (pixEn),
    .frameStart (frameStart),
    .termCount  (termCount),
    .strobe     (strobe),
    .starPixel  (starPixel)
  );

  starfield_dp #(
    .STAGE_W    (STAGE_W),
    .NUM_STAGES (NUM_STAGES),
    .HCNT_W     (HCNT_W),
    .VCNT_W     (VCNT_W),
    .RELOAD_MAP (RELOAD_MAP),
    .FRAME_SEED (FRAME_SEED)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .hCount    (hCount),
    .vCount    (vCount),
    .termCount (termCount)
  );

  // R2 / R4 / R5: a star only on an enabled, non-frame-start pixel
  assert_star_qual_R2: assert property (@(posedge clk) disable iff (!rst_n)
    starPixel |-> (pixEn && !frameStart));

endmodule

// File: tb/starfield_gen_tb.sv
`timescale 1ns/1ps
module starfield_gen_tb;

  localparam int HW = 6;
  localparam int VW = 5;
  localparam int NPIX = (1 << HW) * (1 << VW);
  localparam logic [63:0] MAP = {8'd8, 8'd2, 8'd10, 8'd5, 8'd9, 8'd0, 8'd7, 8'd3};
  localparam logic [7:0] SEED = 8'hF0;

  logic clk = 0;
  logic rst_n = 0;
  logic pixEn = 0;
  logic [HW-1:0] hCount = '0;
  logic [VW-1:0] vCount = '0;
  logic frameStart = 0;
  logic starPixel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] mCnt;
  bit starMap [3][NPIX];
  int lastStar, gapA, distinctGaps;

  always #2 clk = ~clk;

  starfield_gen #(
    .STAGE_W(4), .NUM_STAGES(2), .HCNT_W(HW), .VCNT_W(VW),
    .RELOAD_MAP(MAP), .FRAME_SEED(SEED)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pixEn(pixEn), .hCount(hCount),
    .vCount(vCount), .frameStart(frameStart), .starPixel(starPixel)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R3: permuted reload value computed from the mapping
  function automatic logic [7:0] reloadOf(input logic [HW-1:0] h, input logic [VW-1:0] v);
    logic [HW+VW-1:0] src;
    logic [7:0] r;
    src = {v, h};
    for (int i = 0; i < 8; i++) r[i] = src[MAP[i*8 +: 8]];
    return r;
  endfunction

  // One enabled pixel: drive at negedge, check mid-cycle, model update.
  task automatic pixel(input int f, input int h, input int v);
    bit fs, exp;
    fs = (h == 0 && v == 0);
    @(negedge clk);
    pixEn = 1; hCount = HW'(h); vCount = VW'(v); frameStart = fs;
    #1;
    exp = !fs && (mCnt == 8'hFF);
    // R1 R2 R3 R4: star exactly where the model counter is all ones
    check(starPixel == exp, fs ? "R4" : "R2", starPixel, exp);
    starMap[f][v*(1<<HW)+h] = starPixel;
    if (fs) mCnt = SEED;
    else if (exp) mCnt = reloadOf(HW'(h), VW'(v));
    else mCnt = mCnt + 8'd1;
  endtask

  task automatic idle(input int k);
    @(negedge clk);
    pixEn = 0; hCount = HW'(k * 7); vCount = VW'(k * 3); frameStart = (k % 2 == 0);
    #1;
    // R5: no star while disabled
    check(starPixel == 0, "R5", starPixel, 0);
  endtask

  initial begin
    mCnt = SEED;
    repeat (3) @(negedge clk);
    #1;
    // R6: output low in reset
    check(starPixel == 0, "R6", starPixel, 0);
    @(negedge clk);
    rst_n = 1;
    for (int k = 1; k < 6; k++) idle(k);  // R5: held at the seed, checked by the frames that follow
    for (int f = 0; f < 3; f++) begin
      for (int v = 0; v < (1 << VW); v++)
        for (int h = 0; h < (1 << HW); h++) begin
          pixel(f, h, v);
          if (f == 2 && ((v * 64 + h) % 5 == 3)) idle(h + v);
        end
    end
    // R7: frames identical, including the one with stalls
    for (int p = 0; p < NPIX; p++) begin
      check(starMap[0][p] == starMap[1][p], "R7", starMap[1][p], starMap[0][p]);
      check(starMap[0][p] == starMap[2][p], "R7", starMap[2][p], starMap[0][p]);
    end
    // R8: gaps between stars vary
    lastStar = -1; gapA = -1; distinctGaps = 0;
    for (int p = 0; p < NPIX; p++) begin
      if (starMap[0][p]) begin
        if (lastStar >= 0) begin
          if (gapA < 0) begin gapA = p - lastStar; distinctGaps = 1; end
          else if (p - lastStar != gapA) distinctGaps = 2;
        end
        lastStar = p;
      end
    end
    check(distinctGaps == 2, "R8", distinctGaps, 2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule